// File: doc/BRIEF.md
# Timer Match Action Controller

This block sits next to a free-running timer counter and compares its count against four programmable match values. Each match value has its own three-bit action group. The group can raise an interrupt, clear the count, or halt the counter and drop its enable. The actions go back to the counter core as single-cycle command strobes. The interrupt leaves the block as one level output.

Software programs the match values and the action word through a simple write port. Every match sets a sticky per-register flag, whether or not its interrupt enable is set. The same write port clears these flags by writing ones. The counter core drives `run_i` high while it is counting. Matches are only recognised while `run_i` is high, so a halted counter that holds a matching value does not keep firing.

Top module: `mr_action_ctrl`

## Requirements
- R1: After reset, `tc_clr_o`, `halt_o` and `irq_o` are low, `flag_o` is zero, and all match values and action bits are zero.
- R2: A write with address k (0 to 3) loads match value k. Address 4 loads the action word from `wr_data_i[11:0]`, and bits 31:12 are ignored. Address 5 is the flag-clear address. Addresses 6 and 7 change nothing.
- R3: Match register k's action group occupies bits 3k+2:3k of the action word: bit 3k enables its interrupt, bit 3k+1 clears the count on a match, and bit 3k+2 halts the counter on a match.
- R4: Register k hits only in a cycle where `run_i` is high and `tc_i` equals match value k. A different count, or `run_i` low, gives no hit and no action.
- R5: In a cycle where a register with its clear bit set hits, `tc_clr_o` is high in that same cycle. The core then zeroes both the count and the prescale count at the next clock edge.
- R6: In a cycle where a register with its halt bit set hits, `halt_o` is high in that same cycle. If clear is also set, `tc_clr_o` is high too. Halt wins for the enable: the enable is cleared.
- R7: Every hit of register k sets `flag_o[k]` at the next clock edge, whatever its interrupt enable says. The flag then stays set until it is cleared.
- R8: `irq_o` is the OR over k of `flag_o[k]` AND the interrupt-enable bit of register k.
- R9: A write to address 5 clears each `flag_o[k]` whose `wr_data_i[k]` is 1. Data bits that are 0 leave their flags as they are.
- R10: If a flag's clear and a new hit of the same register fall in the same cycle, the flag ends up set.
- R11: When several registers hit in one cycle, every one of their enabled actions and flags applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| run_i | input | 1 | Counter is enabled and counting |
| tc_i | input | 32 | Current timer count |
| tc_clr_o | output | 1 | Clear the count and prescale count at the next edge |
| halt_o | output | 1 | Freeze the counters and clear the counter enable |
| irq_o | output | 1 | Interrupt request |
| flag_o | output | 4 | Sticky match flags |

## Verification
The hardest case to reach from the ports is a flag-clear write that lands in the same cycle as a new hit of the same register. The bench drives the clear-address write and the matching count with `run_i` together between two edges, so the set and the clear meet in the flag register. Another hard case needs two registers that hold the same value but have different action groups. That stimulus checks that both strobes and both flags appear from one count value.

// File: rtl/mr_pkg.sv
package mr_pkg;
  localparam int unsigned ACT_W = 3;

  typedef struct packed {
    logic halt;
    logic clr;
    logic irq_en;
  } act_t;
endpackage

// File: rtl/mr_regs.sv
module mr_regs
  import mr_pkg::*;
#(
  parameter int unsigned N_MATCH = 4,
  parameter int unsigned TC_W    = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  output logic [N_MATCH-1:0][TC_W-1:0]   match_o,
  output act_t [N_MATCH-1:0]             act_o
);
  localparam int unsigned CTRL_W    = ACT_W * N_MATCH;
  localparam int unsigned CTRL_ADDR = N_MATCH;

  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else if (wr_en_i && wr_addr_i == ADDR_W'(CTRL_ADDR)) ctrl_q <= wr_data_i[CTRL_W-1:0];
  end

  for (genvar k = 0; k < N_MATCH; k++) begin : g_mr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) match_o[k] <= '0;
      else if (wr_en_i && wr_addr_i == ADDR_W'(k)) match_o[k] <= wr_data_i[TC_W-1:0];
    end
    assign act_o[k] = act_t'(ctrl_q[ACT_W*k +: ACT_W]);

    AST_MATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wr_en_i && wr_addr_i == ADDR_W'(k)) |=> $stable(match_o[k])); // R2
  end
endmodule

// File: rtl/mr_compare.sv
module mr_compare #(
  parameter int unsigned N_MATCH = 4,
  parameter int unsigned TC_W    = 32
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         run_i,
  input  logic [TC_W-1:0]              tc_i,
  input  logic [N_MATCH-1:0][TC_W-1:0] match_i,
  output logic [N_MATCH-1:0]           hit_o
);
  for (genvar k = 0; k < N_MATCH; k++) begin : g_cmp
    assign hit_o[k] = run_i && (tc_i == match_i[k]);
  end

  AST_NO_HIT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> hit_o == '0); // R4
endmodule

// File: rtl/mr_flags.sv
module mr_flags #(
  parameter int unsigned N_MATCH = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_MATCH-1:0] hit_i,
  input  logic [N_MATCH-1:0] clr_i,
  output logic [N_MATCH-1:0] flag_o
);
  // a new hit overrides a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr_i) | hit_i;
  end

  for (genvar k = 0; k < N_MATCH; k++) begin : g_chk
    AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hit_i[k] |=> flag_o[k]); // R10
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[k] && !clr_i[k]) |=> flag_o[k]); // R7
  end
endmodule

// File: rtl/mr_action_ctrl.sv
module mr_action_ctrl
  import mr_pkg::*;
#(
  parameter int unsigned N_MATCH = 4,
  parameter int unsigned TC_W    = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic               run_i,
  input  logic [TC_W-1:0]    tc_i,
  output logic               tc_clr_o,
  output logic               halt_o,
  output logic               irq_o,
  output logic [N_MATCH-1:0] flag_o
);
  localparam int unsigned CLR_ADDR = N_MATCH + 1;

  logic [N_MATCH-1:0][TC_W-1:0] match;
  act_t [N_MATCH-1:0]           act;
  logic [N_MATCH-1:0]           hit;
  logic [N_MATCH-1:0]           clr_hit, halt_hit, irq_mask, flag_clr;

  mr_regs #(.N_MATCH(N_MATCH), .TC_W(TC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .match_o(match), .act_o(act)
  );

  mr_compare #(.N_MATCH(N_MATCH), .TC_W(TC_W)) u_cmp (
    .clk_i, .rst_ni, .run_i, .tc_i, .match_i(match), .hit_o(hit)
  );

  assign flag_clr = (wr_en_i && wr_addr_i == ADDR_W'(CLR_ADDR)) ? wr_data_i[N_MATCH-1:0] : '0;

  mr_flags #(.N_MATCH(N_MATCH)) u_flags (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i(flag_clr), .flag_o
  );

  for (genvar k = 0; k < N_MATCH; k++) begin : g_act
    assign clr_hit[k]  = hit[k] & act[k].clr;
    assign halt_hit[k] = hit[k] & act[k].halt;
    assign irq_mask[k] = act[k].irq_en;
  end

  // clear and halt both pass; the core lets halt decide the enable
  assign tc_clr_o = |clr_hit;
  assign halt_o   = |halt_hit;
  assign irq_o    = |(flag_o & irq_mask);

  AST_CLR_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_clr_o |-> run_i); // R5
  AST_HALT_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> run_i); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_o != '0)); // R8
  AST_CLR_WRITE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && wr_en_i && wr_addr_i == ADDR_W'(CLR_ADDR) && wr_data_i[0]) |=> !flag_o[0]); // R9
endmodule

// File: tb/tb_mr_action_ctrl.sv
module tb_mr_action_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        run = 0;
  logic [31:0] tc = '0;
  logic        tc_clr, halt, irq;
  logic [3:0]  flag;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mr_action_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .run_i(run), .tc_i(tc), .tc_clr_o(tc_clr), .halt_o(halt), .irq_o(irq), .flag_o(flag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // one cycle of counting at value v; strobes sampled before the edge
  task automatic pulse(input logic [31:0] v, output logic c, output logic h);
    @(negedge clk);
    run = 1; tc = v;
    #1; c = tc_clr; h = halt;
    @(negedge clk);
    run = 0;
  endtask

  task automatic t_reset;
    chk("R1 tc_clr", tc_clr, 0);
    chk("R1 halt", halt, 0);
    chk("R1 irq", irq, 0);
    chk("R1 flag", flag, 0);
  endtask

  task automatic t_clear_action;
    logic c, h;
    wr(3'd0, 32'd100);
    wr(3'd4, 32'h2);           // R3 bit1: MR0 clear
    pulse(32'd99, c, h);
    chk("R4 miss value", c, 0);
    chk("R4 no flag on miss", flag, 0);
    @(negedge clk); tc = 32'd100; run = 0; #1;
    chk("R4 run low", tc_clr, 0);
    pulse(32'd100, c, h);
    chk("R5 clear strobe", c, 1);
    chk("R5 no halt", h, 0);
    chk("R7 flag without enable", flag, 4'b0001);
    chk("R8 irq masked", irq, 0);
  endtask

  task automatic t_irq_w1c;
    wr(3'd4, 32'h3);
    chk("R8 irq enabled", irq, 1);
    wr(3'd5, 32'h0);
    chk("R9 zero write keeps", flag, 4'b0001);
    wr(3'd5, 32'h1);
    chk("R9 w1c clears", flag, 0);
    chk("R8 irq drops", irq, 0);
  endtask

  task automatic t_halt;
    logic c, h;
    wr(3'd3, 32'd500);
    wr(3'd4, 32'hE00);         // R3 MR3 bits 11,10,9
    pulse(32'd500, c, h);
    chk("R6 halt strobe", h, 1);
    chk("R6 clear also", c, 1);
    chk("R7 flag3", flag, 4'b1000);
    chk("R8 irq mr3", irq, 1);
    wr(3'd5, 32'hF);
  endtask

  task automatic t_multi;
    logic c, h;
    wr(3'd1, 32'd7);
    wr(3'd2, 32'd7);
    wr(3'd4, 32'hA8);          // MR1 halt+irq, MR2 clear
    pulse(32'd7, c, h);
    chk("R11 halt from mr1", h, 1);
    chk("R11 clear from mr2", c, 1);
    chk("R11 both flags", flag, 4'b0110);
    chk("R11 irq", irq, 1);
    wr(3'd5, 32'hF);
  endtask

  task automatic t_set_wins;
    @(negedge clk);
    run = 1; tc = 32'd7;
    @(negedge clk);            // flags 1,2 set
    wr_en = 1; wr_addr = 3'd5; wr_data = 32'h6;
    @(negedge clk);
    wr_en = 0; run = 0;
    chk("R10 set beats clear", flag, 4'b0110);
    wr(3'd5, 32'hF);
    chk("R9 cleared after", flag, 0);
  endtask

  task automatic t_ignored;
    logic c, h;
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'hFFFF_FFFF);
    chk("R2 unmapped flags", flag, 0);
    pulse(32'd7, c, h);        // MR1/MR2 still hold 7, actions unchanged
    chk("R2 unmapped halt", h, 1);
    chk("R2 unmapped clear", c, 1);
    wr(3'd5, 32'hF);
    wr(3'd4, 32'hFFFF_F000);   // reserved bits only
    pulse(32'd7, c, h);
    chk("R2 reserved halt", h, 0);
    chk("R2 reserved clear", c, 0);
    chk("R8 reserved irq", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_clear_action;
    t_irq_w1c;
    t_halt;
    t_multi;
    t_set_wins;
    t_ignored;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule